// File: doc/BRIEF.md
# Serial Flash Page-Buffer Command Engine

This block is the device-side logic of a paged flash that is driven over SPI. It handles the three page-level commands that move data between the main page array and one of two on-chip page buffers. These are loading a page into a buffer, comparing a page with a buffer, and rewriting a page through a buffer. The host sends one opcode byte and three address bytes while chip select is low. The opcode alone picks both the operation and the buffer.

The command only takes effect when chip select rises after all 32 bits have arrived. The engine then pulls the page number out of the address. Where that field sits depends on the page-size mode pin. The engine starts the internal operation and shows busy on the status byte and on a ready pin for a fixed, parameterised number of clock cycles. The page array and the buffers are small behavioural register arrays with a reduced page count. After reset, page p byte w holds (p*WORDS + w) XOR 0x5A and both buffers hold zero.

Top module: `pgbuf_engine`

## Requirements
- R1: Opcode 0x53 copies the addressed main page into buffer A and opcode 0x55 copies it into buffer B. The other buffer is left unchanged.
- R2: Opcode 0x60 compares the addressed page with buffer A and opcode 0x61 compares it with buffer B. When the compare completes, status bit 6 becomes 0 on a match and 1 on a mismatch. The bit keeps its old value while the compare is still busy.
- R3: Opcode 0x58 rewrites the addressed page through buffer A and opcode 0x59 rewrites it through buffer B. The page is first copied into that buffer and then written back unchanged. The other buffer is untouched.
- R4: A command is 32 bits: the opcode followed by 24 address bits, sampled MSB first on rising SCK edges while cs_n is low (SPI mode 0). Nothing starts while cs_n stays low.
- R5: When bin_mode is 0, the page number is address bits 23..11 and bits 10..0 are ignored. When bin_mode is 1, the page number is address bits 22..10 and bits 9..0 are ignored. The low log2(PAGES) bits of the page number select the page.
- R6: status[7] is 1 when ready and 0 when busy, and rdy always equals status[7]. status[5:0] always read 0.
- R7: Busy begins at the first clock edge that sees cs_n high. It lasts T_XFR cycles for a load, T_CMP cycles for a compare and T_RW cycles for a rewrite, and T_RW is the longest.
- R8: A command with fewer than 32 bits, or with any opcode not listed above, is discarded when cs_n rises. It starts no busy period and changes no buffer.
- R9: A command that completes while the engine is busy is discarded.
- R10: After reset the status byte reads 0x80 and rdy is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SPI pins are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| si | input | 1 | SPI serial data in |
| bin_mode | input | 1 | Page-size mode: 0 standard, 1 binary |
| status | output | 8 | Status byte: bit 7 ready, bit 6 compare mismatch |
| rdy | output | 1 | Ready/busy pin, 1 when ready |

## Verification
The bench sends commands whose address field decodes to different pages depending on the mode. A design that used the wrong bit slice, or let the don't-care bits leak into the page number, would load the wrong page, and a later compare would flag a mismatch. It cuts commands short, sends an unknown opcode and holds chip select low after a full command. A design that acted before chip select rose, or accepted a partial frame, would show busy or alter a buffer. It also issues a load while a rewrite is still running. A design without the busy gate would overwrite buffer A and turn a later mismatch into a match. Busy length is checked at the exact edge for all three operations, and status bit 6 is checked while the compare is still busy to catch an early update.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_XFER = 2'd1,
    OP_CMP  = 2'd2,
    OP_RW   = 2'd3
  } pg_op_e;

  typedef struct packed {
    pg_op_e op;
    logic   bsel;   // 0: buffer A, 1: buffer B
  } pg_cmd_t;

  function automatic pg_cmd_t decode_opcode(input logic [7:0] code);
    pg_cmd_t c;
    c.op   = OP_NONE;
    c.bsel = 1'b0;
    case (code)
      8'h53: begin c.op = OP_XFER; c.bsel = 1'b0; end
      8'h55: begin c.op = OP_XFER; c.bsel = 1'b1; end
      8'h60: begin c.op = OP_CMP;  c.bsel = 1'b0; end
      8'h61: begin c.op = OP_CMP;  c.bsel = 1'b1; end
      8'h58: begin c.op = OP_RW;   c.bsel = 1'b0; end
      8'h59: begin c.op = OP_RW;   c.bsel = 1'b1; end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pgbuf_shift.sv
module pgbuf_shift #(
  parameter int CMD_BITS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck,
  input  logic                cs_n,
  input  logic                si,
  output logic [CMD_BITS-1:0] word,
  output logic                full,
  output logic                cs_rise
);
  localparam int CNT_W = $clog2(CMD_BITS + 1);

  logic                sck_q, cs_q;
  logic [CMD_BITS-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                sck_rise;

  always_comb begin
    sck_rise = sck & ~sck_q & ~cs_n;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    if (cs_n) begin
      cnt_d = '0;
    end else if (sck_rise && (cnt_q != CNT_W'(CMD_BITS))) begin
      sh_d  = {sh_q[CMD_BITS-2:0], si};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign word    = sh_q;
  assign full    = (cnt_q == CNT_W'(CMD_BITS));
  assign cs_rise = cs_n & ~cs_q;

endmodule

// File: rtl/pgbuf_timer.sv
module pgbuf_timer
  import pgbuf_pkg::*;
#(
  parameter int T_XFR = 30,
  parameter int T_CMP = 40,
  parameter int T_RW  = 100
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  pg_op_e op,
  output logic   busy,
  output logic   done
);
  localparam int CNT_W = $clog2(T_RW + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      case (op)
        OP_XFER: cnt_d = CNT_W'(T_XFR);
        OP_CMP:  cnt_d = CNT_W'(T_CMP);
        OP_RW:   cnt_d = CNT_W'(T_RW);
        default: cnt_d = cnt_q;
      endcase
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pgbuf_store.sv
module pgbuf_store
  import pgbuf_pkg::*;
#(
  parameter int PAGES = 8,
  parameter int WORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  pg_op_e                   op,
  input  logic                     bsel,
  input  logic [$clog2(PAGES)-1:0] page,
  input  logic                     done,
  output logic                     mismatch
);
  localparam int PG_W  = $clog2(PAGES);
  localparam int ROW_W = WORDS * 8;

  logic [ROW_W-1:0] main_q [PAGES];
  logic [ROW_W-1:0] buf_q  [2];
  logic             sel_q, wb_q;
  logic [PG_W-1:0]  pg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PAGES; p++) begin
        for (int w = 0; w < WORDS; w++) begin
          main_q[p][w*8 +: 8] <= 8'(p * WORDS + w) ^ 8'h5A;
        end
      end
      buf_q[0] <= '0;
      buf_q[1] <= '0;
      sel_q    <= 1'b0;
      wb_q     <= 1'b0;
      pg_q     <= '0;
    end else begin
      if (start) begin
        if (op == OP_XFER || op == OP_RW) buf_q[bsel] <= main_q[page];
        sel_q <= bsel;
        pg_q  <= page;
        wb_q  <= (op == OP_RW);
      end
      if (done && wb_q) main_q[pg_q] <= buf_q[sel_q];
    end
  end

  assign mismatch = (main_q[page] != buf_q[bsel]);

endmodule

// File: rtl/pgbuf_engine.sv
module pgbuf_engine
  import pgbuf_pkg::*;
#(
  parameter int PAGES = 8,
  parameter int WORDS = 4,
  parameter int T_XFR = 30,
  parameter int T_CMP = 40,
  parameter int T_RW  = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       si,
  input  logic       bin_mode,
  output logic [7:0] status,
  output logic       rdy
);
  localparam int CMD_BITS = 32;
  localparam int PG_W     = $clog2(PAGES);

  logic [CMD_BITS-1:0] word;
  logic                full, cs_rise;
  pg_cmd_t             cmd;
  logic [12:0]         pg_num;
  logic [PG_W-1:0]     pg_idx;
  logic                start, busy, done, mismatch;
  pg_op_e              op_q, op_d;
  logic                cmp_q, cmp_d, mis_q, mis_d;

  pgbuf_shift #(.CMD_BITS(CMD_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .word(word), .full(full), .cs_rise(cs_rise)
  );

  always_comb begin
    cmd    = decode_opcode(word[31:24]);
    pg_num = bin_mode ? word[22:10] : word[23:11];
    pg_idx = pg_num[PG_W-1:0];
    start  = cs_rise & full & (cmd.op != OP_NONE) & ~busy;
  end

  pgbuf_timer #(.T_XFR(T_XFR), .T_CMP(T_CMP), .T_RW(T_RW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .op(cmd.op),
    .busy(busy), .done(done)
  );

  pgbuf_store #(.PAGES(PAGES), .WORDS(WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .start(start), .op(cmd.op), .bsel(cmd.bsel),
    .page(pg_idx), .done(done), .mismatch(mismatch)
  );

  always_comb begin
    op_d  = op_q;
    cmp_d = cmp_q;
    mis_d = mis_q;
    if (start) begin
      op_d  = cmd.op;
      cmp_d = mismatch;
    end
    if (done && op_q == OP_CMP) mis_d = cmp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_NONE;
      cmp_q <= 1'b0;
      mis_q <= 1'b0;
    end else begin
      op_q  <= op_d;
      cmp_q <= cmp_d;
      mis_q <= mis_d;
    end
  end

  assign status = {~busy, mis_q, 6'b0};
  assign rdy    = ~busy;

endmodule

// File: rtl/pgbuf_engine_chk.sv
module pgbuf_engine_chk #(
  parameter int T_RW = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic [7:0] status,
  input logic       rdy
);
  localparam int BC_W = $clog2(T_RW + 2);

  logic [BC_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_cnt <= '0;
    else if (!status[7]) busy_cnt <= busy_cnt + 1'b1;
    else                 busy_cnt <= '0;
  end

  p_pin_tracks_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdy == status[7]);

  p_low_bits_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status[5:0] == 6'b0);

  p_start_after_cs_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[7]) |-> $past(cs_n));

  p_result_at_completion_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status[6]) |-> $rose(status[7]));

  p_busy_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= BC_W'(T_RW));

endmodule

bind pgbuf_engine pgbuf_engine_chk #(.T_RW(T_RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .status(status), .rdy(rdy)
);

// File: tb/pgbuf_engine_test.sv
module pgbuf_engine_test;
  localparam int T_XFR = 30;
  localparam int T_CMP = 40;
  localparam int T_RW  = 100;

  logic       clk, rst_n, sck, cs_n, si, bin_mode;
  logic [7:0] status;
  logic       rdy;
  int         n_chk, n_bad;
  bit         finished;

  pgbuf_engine #(.PAGES(8), .WORDS(4), .T_XFR(T_XFR), .T_CMP(T_CMP), .T_RW(T_RW)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .bin_mode(bin_mode), .status(status), .rdy(rdy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // shifts nbits of {opcode,addr} MSB first; cs_n left low when keep_low
  task automatic shift_bits(input logic [7:0] opc, input logic [23:0] addr,
                            input int nbits, input bit keep_low);
    logic [31:0] w;
    w = {opc, addr};
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      si = w[31-i];
      @(negedge clk); sck = 1'b1;
      @(negedge clk); sck = 1'b0;
    end
    @(negedge clk);
    if (!keep_low) cs_n = 1'b1;
  endtask

  task automatic run_cmd(input logic [7:0] opc, input logic [23:0] addr);
    shift_bits(opc, addr, 32, 1'b0);
    repeat (T_RW + 3) @(negedge clk);
  endtask

  task automatic cmp_expect(input string req, input logic [7:0] opc,
                            input logic [23:0] addr, input logic exp);
    run_cmd(opc, addr);
    check(req, {7'b0, status[6]}, {7'b0, exp});
  endtask

  task automatic t_reset;
    check("R10 reset status", status, 8'h80);
    check("R10 reset rdy", {7'b0, rdy}, 8'h01);
  endtask

  task automatic t_cmp_timing;
    shift_bits(8'h60, 24'(1 << 11), 32, 1'b0);
    repeat (T_CMP) @(negedge clk);
    check("R7 compare busy last cycle", status, 8'h00);
    check("R2 bit6 held while busy", {7'b0, status[6]}, 8'h00);
    check("R6 rdy low when busy", {7'b0, rdy}, 8'h00);
    @(negedge clk);
    check("R2 mismatch result zero buffer", status, 8'hC0);
    check("R6 rdy high when ready", {7'b0, rdy}, 8'h01);
  endtask

  task automatic t_xfer_a;
    shift_bits(8'h53, 24'(1 << 11), 32, 1'b0);
    repeat (T_XFR) @(negedge clk);
    check("R7 transfer busy last cycle", {7'b0, status[7]}, 8'h00);
    @(negedge clk);
    check("R7 transfer ready after period", {7'b0, status[7]}, 8'h01);
    shift_bits(8'h60, 24'(1 << 11), 32, 1'b0);
    repeat (T_CMP) @(negedge clk);
    check("R2 bit6 old value while busy", {7'b0, status[6]}, 8'h01);
    @(negedge clk);
    check("R1 page1 in buffer A matches", {7'b0, status[6]}, 8'h00);
  endtask

  task automatic t_xfer_b;
    cmp_expect("R1 buffer B untouched by 0x53", 8'h61, 24'(1 << 11), 1'b1);
    run_cmd(8'h55, 24'(2 << 11));
    cmp_expect("R1 page2 in buffer B", 8'h61, 24'(2 << 11), 1'b0);
    cmp_expect("R1 buffer A untouched by 0x55", 8'h60, 24'(2 << 11), 1'b1);
  endtask

  task automatic t_rewrite;
    shift_bits(8'h59, 24'(4 << 11), 32, 1'b0);
    repeat (T_XFR + 1) @(negedge clk);
    check("R7 rewrite busy beyond transfer period", {7'b0, status[7]}, 8'h00);
    repeat (T_RW - T_XFR - 1) @(negedge clk);
    check("R7 rewrite busy last cycle", {7'b0, status[7]}, 8'h00);
    @(negedge clk);
    check("R7 rewrite ready after period", {7'b0, status[7]}, 8'h01);
    cmp_expect("R3 page4 copied to buffer B and kept", 8'h61, 24'(4 << 11), 1'b0);
    cmp_expect("R3 buffer A untouched by rewrite", 8'h60, 24'(1 << 11), 1'b0);
    run_cmd(8'h58, 24'(0 << 11));
    cmp_expect("R3 rewrite via buffer A", 8'h60, 24'(0 << 11), 1'b0);
  endtask

  task automatic t_decode;
    bin_mode = 1'b0;
    run_cmd(8'h53, 24'(6 << 10));
    cmp_expect("R5 standard mode slice 23..11 gives page3", 8'h60, 24'(3 << 11), 1'b0);
    bin_mode = 1'b1;
    run_cmd(8'h53, 24'(6 << 10));
    bin_mode = 1'b0;
    cmp_expect("R5 binary mode slice 22..10 gives page6", 8'h60, 24'(6 << 11), 1'b0);
    run_cmd(8'h55, 24'((5 << 11) | 11'h7FF));
    cmp_expect("R5 standard low bits ignored", 8'h61, 24'(5 << 11), 1'b0);
    bin_mode = 1'b1;
    run_cmd(8'h53, 24'((7 << 10) | 10'h3FF));
    cmp_expect("R5 binary low bits ignored", 8'h60, 24'(7 << 10), 1'b0);
    bin_mode = 1'b0;
  endtask

  task automatic t_discard;
    shift_bits(8'h53, 24'(2 << 11), 31, 1'b0);
    repeat (2) @(negedge clk);
    check("R8 short frame no busy", status, 8'h80);
    shift_bits(8'h54, 24'(2 << 11), 32, 1'b0);
    repeat (2) @(negedge clk);
    check("R8 unknown opcode no busy", status, 8'h80);
    cmp_expect("R8 buffer A unchanged by discards", 8'h60, 24'(2 << 11), 1'b1);
    shift_bits(8'h53, 24'(2 << 11), 32, 1'b1);
    repeat (20) @(negedge clk);
    check("R4 no start while cs_n low", {7'b0, status[7]}, 8'h01);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 starts once cs_n rises", {7'b0, status[7]}, 8'h00);
    repeat (T_RW) @(negedge clk);
    cmp_expect("R4 MSB-first frame loaded page2", 8'h60, 24'(2 << 11), 1'b0);
  endtask

  task automatic t_busy_ignore;
    shift_bits(8'h59, 24'(3 << 11), 32, 1'b0);
    shift_bits(8'h53, 24'(3 << 11), 32, 1'b0);
    repeat (2) @(negedge clk);
    check("R9 still busy from rewrite", {7'b0, status[7]}, 8'h00);
    repeat (T_RW + 3) @(negedge clk);
    check("R9 ready after rewrite", {7'b0, status[7]}, 8'h01);
    cmp_expect("R9 load issued while busy dropped", 8'h60, 24'(3 << 11), 1'b1);
    cmp_expect("R9 rewrite itself took effect", 8'h61, 24'(3 << 11), 1'b0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0; bin_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmp_timing();
    t_xfer_a();
    t_xfer_b();
    t_rewrite();
    t_decode();
    t_discard();
    t_busy_ignore();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule